// File: doc/BRIEF.md
# Presence-Vector Directory Coherence Controller

This block is the memory-side coherence directory for a small shared-memory system of `NUM_PE` processing elements. It keeps one entry per memory block. Each entry holds one presence bit per processing element and a single dirty flag. A set dirty flag means exactly one element, whose presence bit is set, owns a modified copy.

Requesters present read, write-ownership or eviction requests through a valid/ready handshake. The controller handles one request at a time. It sends addressed messages, one per cycle, only to the elements named in the entry and never to all of them at once. These messages either invalidate a copy or recall modified data. The controller collects an acknowledgement from every element it messaged. It writes recalled or evicted data back to the external memory, updates the entry, and then answers the requester with a one-cycle reply that carries the line data.

The caches, the interconnect and the data memory sit outside the block. The memory port has a one-cycle read latency.

Top module: `dir_ctrl`

## Requirements
- R1: While reset is applied and while idle, `req_ready` is 1 and `msg_valid`, `rsp_valid`, `mem_rd_en` and `mem_wr_en` are 0.
- R2: A read (`req_op`=0) of a block whose dirty flag is clear sends no message. The reply carries the memory contents, and the requester becomes a sharer.
- R3: A read of a dirty block sends one message of kind 1 (recall, keep shared copy) to the owner only. The owner's acknowledged data is written to memory and returned. The dirty flag clears, and the owner stays a sharer.
- R4: A write request (`req_op`=1) to a clean block sends a message of kind 0 (invalidate) to every present element except the requester and to no one else. The reply carries memory data. Afterwards only the requester is present and the block is dirty.
- R5: A write request to a block dirty in another element sends kind 2 (recall and invalidate) to that owner. The recalled data is written to memory and returned, and ownership passes to the requester.
- R6: The reply is never given while any acknowledgement from a messaged element is outstanding.
- R7: Messages go out at most one per cycle. Each carries the request's block address, and no element receives more than one message per request.
- R8: An eviction (`req_op`=2) from the current dirty owner writes `req_wdata` to memory and clears the dirty flag and that element's presence bit. An eviction from any other element changes neither memory nor the entry. Both kinds of eviction are answered with a reply that carries `req_wdata`.
- R9: `req_ready` is 0 from the cycle after a request is accepted through the reply cycle, and it returns to 1 on the cycle after the reply.
- R10: A write request from the element that already owns the block dirty sends no message and replies with memory data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle and accepting |
| req_pe | input | PE_W | Requesting element index |
| req_op | input | 2 | 0 read, 1 write ownership, 2 eviction write-back |
| req_addr | input | ADDR_W | Block index |
| req_wdata | input | DATA_W | Eviction data |
| rsp_valid | output | 1 | One-cycle reply strobe |
| rsp_pe | output | PE_W | Element the reply is for |
| rsp_data | output | DATA_W | Line data returned |
| msg_valid | output | 1 | Coherence message strobe |
| msg_pe | output | PE_W | Message destination |
| msg_kind | output | 2 | 0 invalidate, 1 recall keep shared, 2 recall and invalidate |
| msg_addr | output | ADDR_W | Block the message concerns |
| ack_valid | input | 1 | Acknowledgement strobe |
| ack_pe | input | PE_W | Acknowledging element |
| ack_has_data | input | 1 | Acknowledgement carries recalled data |
| ack_data | input | DATA_W | Recalled line data |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_wr_en | output | 1 | Memory write strobe |
| mem_addr | output | ADDR_W | Memory block index |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data, valid one cycle after `mem_rd_en` |

## Verification
The hardest situation to reach is a write that must invalidate several sharers whose acknowledgements come back late and in an order different from the order the messages went out. Reaching it takes a history of reads from distinct elements on the same block. The acknowledging stub therefore gives each element a delay that depends on its index and on the transaction number, and it answers the highest-numbered ready element first. A long deterministic sweep of mixed operations over four blocks builds up sharer sets of every size. The same sweep also produces dirty owners that are then read, overtaken or evicted by themselves and by others. A reference model in the bench predicts the destination set, message kind, reply data and memory image for each request.

// File: rtl/dir_pkg.sv
package dir_pkg;

  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_WRITE = 2'd1,
    OP_EVICT = 2'd2
  } dir_op_e;

  typedef enum logic [1:0] {
    MSG_INVAL      = 2'd0,
    MSG_RECALL_SH  = 2'd1,
    MSG_RECALL_INV = 2'd2
  } dir_msg_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DECIDE,
    ST_FANOUT,
    ST_MEMRD,
    ST_MEMWR,
    ST_REPLY
  } dir_state_e;

endpackage

// File: rtl/dir_rst_sync.sv
module dir_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_n_out = sync_q[1];

endmodule

// File: rtl/dir_store.sv
module dir_store #(
  parameter int NUM_PE = 4,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [NUM_PE-1:0] rd_pres,
  output logic              rd_dirty,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [NUM_PE-1:0] wr_pres,
  input  logic              wr_dirty
);

  localparam int NUM_BLK = 1 << ADDR_W;

  logic [NUM_PE-1:0] pres_q  [NUM_BLK];
  logic              dirty_q [NUM_BLK];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int b = 0; b < NUM_BLK; b++) begin
        pres_q[b]  <= '0;
        dirty_q[b] <= 1'b0;
      end
    end else if (wr_en) begin
      pres_q[wr_addr]  <= wr_pres;
      dirty_q[wr_addr] <= wr_dirty;
    end
  end

  assign rd_pres  = pres_q[rd_addr];
  assign rd_dirty = dirty_q[rd_addr];

endmodule

// File: rtl/dir_fanout.sv
module dir_fanout #(
  parameter int NUM_PE = 4,
  parameter int PE_W   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [NUM_PE-1:0] load_mask,
  input  logic              ack_valid,
  input  logic [PE_W-1:0]   ack_pe,
  output logic              send_valid,
  output logic [PE_W-1:0]   send_pe,
  output logic [NUM_PE-1:0] wait_mask,
  output logic              done
);

  logic [NUM_PE-1:0] send_q, send_d;
  logic [NUM_PE-1:0] wait_q, wait_d;
  logic [NUM_PE-1:0] low_bit;
  logic [NUM_PE-1:0] ack_bit;

  // lowest pending destination goes out first
  always_comb begin
    send_pe = '0;
    for (int i = NUM_PE - 1; i >= 0; i--) begin
      if (send_q[i]) send_pe = PE_W'(i);
    end
  end

  assign low_bit = send_q & (~send_q + NUM_PE'(1));
  assign ack_bit = ack_valid ? (NUM_PE'(1) << ack_pe) : '0;

  always_comb begin
    if (load) begin
      send_d = load_mask;
      wait_d = load_mask;
    end else begin
      send_d = send_q & ~low_bit;
      wait_d = wait_q & ~ack_bit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      send_q <= '0;
      wait_q <= '0;
    end else begin
      send_q <= send_d;
      wait_q <= wait_d;
    end
  end

  assign send_valid = |send_q;
  assign wait_mask  = wait_q;
  assign done       = ~(|send_q) & ~(|wait_q);

endmodule

// File: rtl/dir_ctrl.sv
module dir_ctrl #(
  parameter int NUM_PE = 4,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16,
  localparam int PE_W  = (NUM_PE > 1) ? $clog2(NUM_PE) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [PE_W-1:0]   req_pe,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [PE_W-1:0]   rsp_pe,
  output logic [DATA_W-1:0] rsp_data,
  output logic              msg_valid,
  output logic [PE_W-1:0]   msg_pe,
  output logic [1:0]        msg_kind,
  output logic [ADDR_W-1:0] msg_addr,
  input  logic              ack_valid,
  input  logic [PE_W-1:0]   ack_pe,
  input  logic              ack_has_data,
  input  logic [DATA_W-1:0] ack_data,
  output logic              mem_rd_en,
  output logic              mem_wr_en,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata
);

  import dir_pkg::*;

  logic rst_n_s;

  dir_state_e        state_q, state_d;
  logic [PE_W-1:0]   pe_q, pe_d;
  dir_op_e           op_q, op_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  dir_msg_e          kind_q, kind_d;
  logic [DATA_W-1:0] line_q, line_d;
  logic              got_q, got_d;
  logic              from_mem_q, from_mem_d;
  logic              evict_ok_q, evict_ok_d;

  logic [NUM_PE-1:0] rd_pres;
  logic              rd_dirty;
  logic              dir_we;
  logic [NUM_PE-1:0] dir_wpres;
  logic              dir_wdirty;
  logic [NUM_PE-1:0] req_bit;

  logic              fan_load;
  logic [NUM_PE-1:0] fan_mask;
  logic [NUM_PE-1:0] fan_wait;
  logic              fan_done;
  logic              fan_send;
  logic [PE_W-1:0]   fan_pe;

  dir_rst_sync u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_s)
  );

  dir_store #(.NUM_PE(NUM_PE), .ADDR_W(ADDR_W)) u_store (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .rd_addr  (addr_q),
    .rd_pres  (rd_pres),
    .rd_dirty (rd_dirty),
    .wr_en    (dir_we),
    .wr_addr  (addr_q),
    .wr_pres  (dir_wpres),
    .wr_dirty (dir_wdirty)
  );

  dir_fanout #(.NUM_PE(NUM_PE), .PE_W(PE_W)) u_fan (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .load       (fan_load),
    .load_mask  (fan_mask),
    .ack_valid  (ack_valid),
    .ack_pe     (ack_pe),
    .send_valid (fan_send),
    .send_pe    (fan_pe),
    .wait_mask  (fan_wait),
    .done       (fan_done)
  );

  assign req_bit = NUM_PE'(1) << pe_q;

  // next-state process
  always_comb begin
    state_d    = state_q;
    pe_d       = pe_q;
    op_d       = op_q;
    addr_d     = addr_q;
    kind_d     = kind_q;
    line_d     = line_q;
    got_d      = got_q;
    from_mem_d = from_mem_q;
    evict_ok_d = evict_ok_q;
    fan_load   = 1'b0;
    fan_mask   = '0;
    mem_rd_en  = 1'b0;
    mem_wr_en  = 1'b0;
    rsp_valid  = 1'b0;
    dir_we     = 1'b0;
    dir_wpres  = rd_pres;
    dir_wdirty = rd_dirty;

    // recalled data from an awaited element is captured as it arrives
    if (ack_valid && ack_has_data && fan_wait[ack_pe]) begin
      line_d = ack_data;
      got_d  = 1'b1;
    end

    case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          pe_d       = req_pe;
          op_d       = dir_op_e'(req_op);
          addr_d     = req_addr;
          line_d     = req_wdata;
          got_d      = 1'b0;
          from_mem_d = 1'b0;
          evict_ok_d = 1'b0;
          state_d    = ST_DECIDE;
        end
      end

      ST_DECIDE: begin
        case (op_q)
          OP_READ: begin
            if (rd_dirty) begin
              fan_load = 1'b1;
              fan_mask = rd_pres;
              kind_d   = MSG_RECALL_SH;
              state_d  = ST_FANOUT;
            end else begin
              state_d  = ST_MEMRD;
            end
          end
          OP_WRITE: begin
            if (rd_dirty && !rd_pres[pe_q]) begin
              fan_load = 1'b1;
              fan_mask = rd_pres;
              kind_d   = MSG_RECALL_INV;
              state_d  = ST_FANOUT;
            end else if (rd_dirty) begin
              state_d  = ST_MEMRD;
            end else if ((rd_pres & ~req_bit) != '0) begin
              fan_load = 1'b1;
              fan_mask = rd_pres & ~req_bit;
              kind_d   = MSG_INVAL;
              state_d  = ST_FANOUT;
            end else begin
              state_d  = ST_MEMRD;
            end
          end
          OP_EVICT: begin
            if (rd_dirty && rd_pres[pe_q]) begin
              evict_ok_d = 1'b1;
              state_d    = ST_MEMWR;
            end else begin
              state_d    = ST_REPLY;
            end
          end
          default: state_d = ST_REPLY;
        endcase
      end

      ST_FANOUT: begin
        if (fan_done) begin
          state_d = got_q ? ST_MEMWR : ST_MEMRD;
        end
      end

      ST_MEMRD: begin
        mem_rd_en  = 1'b1;
        from_mem_d = 1'b1;
        state_d    = ST_REPLY;
      end

      ST_MEMWR: begin
        mem_wr_en = 1'b1;
        state_d   = ST_REPLY;
      end

      ST_REPLY: begin
        rsp_valid = 1'b1;
        case (op_q)
          OP_READ: begin
            dir_we     = 1'b1;
            dir_wpres  = rd_pres | req_bit;
            dir_wdirty = 1'b0;
          end
          OP_WRITE: begin
            dir_we     = 1'b1;
            dir_wpres  = req_bit;
            dir_wdirty = 1'b1;
          end
          OP_EVICT: begin
            dir_we     = evict_ok_q;
            dir_wpres  = rd_pres & ~req_bit;
            dir_wdirty = 1'b0;
          end
          default: dir_we = 1'b0;
        endcase
        state_d = ST_IDLE;
      end

      default: state_d = ST_IDLE;
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      state_q    <= ST_IDLE;
      pe_q       <= '0;
      op_q       <= OP_READ;
      addr_q     <= '0;
      kind_q     <= MSG_INVAL;
      line_q     <= '0;
      got_q      <= 1'b0;
      from_mem_q <= 1'b0;
      evict_ok_q <= 1'b0;
    end else begin
      state_q    <= state_d;
      pe_q       <= pe_d;
      op_q       <= op_d;
      addr_q     <= addr_d;
      kind_q     <= kind_d;
      line_q     <= line_d;
      got_q      <= got_d;
      from_mem_q <= from_mem_d;
      evict_ok_q <= evict_ok_d;
    end
  end

  assign req_ready = (state_q == ST_IDLE);
  assign rsp_pe    = pe_q;
  assign rsp_data  = from_mem_q ? mem_rdata : line_q;
  assign msg_valid = fan_send;
  assign msg_pe    = fan_pe;
  assign msg_kind  = kind_q;
  assign msg_addr  = addr_q;
  assign mem_addr  = addr_q;
  assign mem_wdata = line_q;

endmodule

// File: rtl/dir_ctrl_chk.sv
module dir_ctrl_chk #(
  parameter int NUM_PE = 4,
  parameter int PE_W   = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              msg_valid,
  input logic [PE_W-1:0]   msg_pe,
  input logic              mem_rd_en,
  input logic              mem_wr_en,
  input logic [NUM_PE-1:0] wait_mask
);

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!msg_valid && !rsp_valid && !mem_rd_en && !mem_wr_en));

  assert_single_mem_op_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd_en && mem_wr_en));

  assert_writeback_then_reply_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |=> rsp_valid);

  assert_reply_after_acks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (wait_mask == '0));

  assert_msg_awaited_R7: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> wait_mask[msg_pe]);

  assert_msg_no_repeat_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && $past(msg_valid)) |-> (msg_pe != $past(msg_pe)));

  assert_busy_after_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  assert_ready_after_reply_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> req_ready);

endmodule

bind dir_ctrl dir_ctrl_chk #(.NUM_PE(NUM_PE), .PE_W(PE_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n_s),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .msg_valid (msg_valid),
  .msg_pe    (msg_pe),
  .mem_rd_en (mem_rd_en),
  .mem_wr_en (mem_wr_en),
  .wait_mask (fan_wait)
);

// File: tb/dir_ctrl_test.sv
module dir_ctrl_test;

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic        req_ready;
  logic [1:0]  req_pe;
  logic [1:0]  req_op;
  logic [3:0]  req_addr;
  logic [15:0] req_wdata;
  logic        rsp_valid;
  logic [1:0]  rsp_pe;
  logic [15:0] rsp_data;
  logic        msg_valid;
  logic [1:0]  msg_pe;
  logic [1:0]  msg_kind;
  logic [3:0]  msg_addr;
  logic        ack_valid;
  logic [1:0]  ack_pe;
  logic        ack_has_data;
  logic [15:0] ack_data;
  logic        mem_rd_en;
  logic        mem_wr_en;
  logic [3:0]  mem_addr;
  logic [15:0] mem_wdata;
  logic [15:0] mem_rdata;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int txn    = 0;

  // memory stub and reference model
  logic [15:0] mem   [16];
  logic [15:0] mmem  [16];
  logic [3:0]  mpres [16];
  logic        mdirty[16];
  logic [15:0] own   [16];

  // per-transaction message observations
  logic [3:0] seen_mask;
  logic [1:0] cur_kind;
  logic [3:0] cur_addr;
  bit         dup, kind_bad, addr_bad;

  // acknowledging element stubs
  logic [3:0] spend;
  int         scnt [4];
  logic [1:0] skind[4];
  logic [3:0] saddr[4];

  dir_ctrl uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_pe(req_pe),
    .req_op(req_op), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_pe(rsp_pe), .rsp_data(rsp_data),
    .msg_valid(msg_valid), .msg_pe(msg_pe), .msg_kind(msg_kind), .msg_addr(msg_addr),
    .ack_valid(ack_valid), .ack_pe(ack_pe), .ack_has_data(ack_has_data), .ack_data(ack_data),
    .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected<150000", cyc);
      summary();
      $finish;
    end
  end

  always @(posedge clk) begin
    if (mem_wr_en) mem[mem_addr] <= mem_wdata;
    if (mem_rd_en) mem_rdata <= mem[mem_addr];
  end

  always @(negedge clk) begin
    if (!rst_n) begin
      ack_valid    = 1'b0;
      ack_pe       = '0;
      ack_has_data = 1'b0;
      ack_data     = '0;
      spend        = '0;
    end else begin
      if (msg_valid) begin
        if (seen_mask[msg_pe]) dup = 1'b1;
        seen_mask[msg_pe] = 1'b1;
        if (msg_kind != cur_kind) kind_bad = 1'b1;
        if (msg_addr != cur_addr) addr_bad = 1'b1;
        spend[msg_pe] = 1'b1;
        scnt[msg_pe]  = ((int'(msg_pe) * 3 + txn) % 4) + 1;
        skind[msg_pe] = msg_kind;
        saddr[msg_pe] = msg_addr;
      end
      ack_valid    = 1'b0;
      ack_pe       = '0;
      ack_has_data = 1'b0;
      ack_data     = '0;
      for (int p = 3; p >= 0; p--) begin
        if (!ack_valid && spend[p] && scnt[p] == 0) begin
          ack_valid    = 1'b1;
          ack_pe       = 2'(p);
          ack_has_data = (skind[p] != 2'd0);
          ack_data     = own[saddr[p]];
          spend[p]     = 1'b0;
        end
      end
      for (int p = 0; p < 4; p++) begin
        if (spend[p] && scnt[p] > 0) scnt[p]--;
      end
    end
  end

  task automatic chk(input bit ok, input string rq, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic do_txn(input int pe, input int op, input int a, input logic [15:0] wd);
    logic [3:0]  bitm;
    logic [3:0]  emask;
    logic [1:0]  ekind;
    logic [15:0] edata;
    string       tag;
    bit          busy_bad;
    bit          mem_ok;
    int          n;
    bitm  = 4'(1 << pe);
    emask = '0;
    ekind = 2'd0;
    edata = '0;
    if (op == 0) begin
      if (mdirty[a]) begin tag = "R3"; emask = mpres[a]; ekind = 2'd1; edata = own[a]; end
      else begin tag = "R2"; edata = mmem[a]; end
    end else if (op == 1) begin
      if (mdirty[a] && !mpres[a][pe]) begin tag = "R5"; emask = mpres[a]; ekind = 2'd2; edata = own[a]; end
      else if (mdirty[a]) begin tag = "R10"; edata = mmem[a]; end
      else begin tag = "R4"; emask = mpres[a] & ~bitm; ekind = 2'd0; edata = mmem[a]; end
    end else begin
      tag = "R8"; edata = wd;
    end

    @(negedge clk);
    seen_mask = '0; dup = 0; kind_bad = 0; addr_bad = 0;
    cur_kind  = ekind; cur_addr = 4'(a); txn++;
    req_valid = 1'b1; req_pe = 2'(pe); req_op = 2'(op); req_addr = 4'(a); req_wdata = wd;
    n = 0;
    while (!req_ready && n < 100) begin @(negedge clk); n++; end
    @(negedge clk);
    req_valid = 1'b0;
    busy_bad = 0;
    n = 0;
    while (!rsp_valid && n < 300) begin
      if (req_ready) busy_bad = 1;
      @(negedge clk);
      n++;
    end
    chk(rsp_valid, tag, "reply arrived", int'(rsp_valid), 1);
    chk(rsp_pe == 2'(pe), tag, "reply element", int'(rsp_pe), pe);
    chk(rsp_data == edata, tag, "reply data", int'(rsp_data), int'(edata));
    chk(seen_mask == emask, (emask != 0) ? tag : "R7", "message targets", int'(seen_mask), int'(emask));
    if (emask != 0) chk(!kind_bad, tag, "message kind", int'(kind_bad), 0);
    chk(!dup && !addr_bad, "R7", "duplicate or misaddressed message", int'(dup) + 2*int'(addr_bad), 0);
    chk(spend == 4'd0, "R6", "acks outstanding at reply", int'(spend), 0);
    chk(!busy_bad && !req_ready, "R9", "ready while busy", int'(busy_bad), 0);

    // reference model update
    if (op == 0) begin
      if (mdirty[a]) begin mmem[a] = own[a]; mdirty[a] = 1'b0; end
      mpres[a] = mpres[a] | bitm;
    end else if (op == 1) begin
      if (mdirty[a] && !mpres[a][pe]) mmem[a] = own[a];
      mpres[a]  = bitm;
      mdirty[a] = 1'b1;
      own[a]    = wd;
    end else if (mdirty[a] && mpres[a][pe]) begin
      mmem[a]   = wd;
      mdirty[a] = 1'b0;
      mpres[a]  = mpres[a] & ~bitm;
    end

    @(negedge clk);
    chk(req_ready, "R9", "ready after reply", int'(req_ready), 1);
    mem_ok = 1;
    for (int b = 0; b < 16; b++) if (mem[b] !== mmem[b]) mem_ok = 0;
    chk(mem_ok, tag, "memory image", int'(mem[a]), int'(mmem[a]));
  endtask

  initial begin
    rst_n = 1'b0;
    req_valid = 1'b0; req_pe = '0; req_op = '0; req_addr = '0; req_wdata = '0;
    seen_mask = '0; cur_kind = '0; cur_addr = '0; spend = '0;
    for (int b = 0; b < 16; b++) begin
      mem[b]    = 16'(b * 16'h0111 + 16'h0a00);
      mmem[b]   = 16'(b * 16'h0111 + 16'h0a00);
      mpres[b]  = '0;
      mdirty[b] = 1'b0;
      own[b]    = '0;
    end
    for (int p = 0; p < 4; p++) begin scnt[p] = 0; skind[p] = '0; saddr[p] = '0; end

    @(negedge clk);
    chk(req_ready && !msg_valid && !rsp_valid && !mem_rd_en && !mem_wr_en,
        "R1", "reset outputs", {27'd0, req_ready, msg_valid, rsp_valid, mem_rd_en, mem_wr_en}, 16);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(req_ready && !msg_valid && !rsp_valid, "R1", "idle outputs",
        {29'd0, req_ready, msg_valid, rsp_valid}, 4);

    // directed corner cases on block 5
    do_txn(0, 0, 5, 16'h0);      // R2 clean read
    do_txn(1, 0, 5, 16'h0);
    do_txn(2, 0, 5, 16'h0);
    do_txn(3, 1, 5, 16'hbeef);   // R4 invalidate three sharers
    do_txn(0, 0, 5, 16'h0);      // R3 recall from owner 3
    do_txn(1, 1, 5, 16'hc0de);   // R4 invalidate 0 and 3
    do_txn(2, 1, 5, 16'hd00d);   // R5 recall-invalidate owner 1
    do_txn(2, 1, 5, 16'hd11d);   // R10 owner rewrites
    do_txn(0, 2, 5, 16'h1234);   // R8 stale eviction ignored
    do_txn(2, 2, 5, 16'h5678);   // R8 owner eviction
    do_txn(3, 0, 5, 16'h0);      // R2 clean after eviction
    do_txn(3, 2, 5, 16'h9999);   // R8 eviction of clean block ignored

    // deterministic sweep over four blocks
    for (int s = 0; s < 400; s++) begin
      int pe, op, a, sel;
      a   = (s / 3 + s) % 4;
      pe  = (s * 7 + s / 9) % 4;
      sel = (s * 13 + s / 4) % 8;
      op  = (sel < 3) ? 0 : (sel < 6) ? 1 : 2;
      if (op == 2 && (s % 2 == 0) && mdirty[a]) begin
        for (int p = 0; p < 4; p++) if (mpres[a][p]) pe = p;
      end
      do_txn(pe, op, a, 16'(s * 97 + 13));
    end

    summary();
    $finish;
  end

endmodule